// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets clocked logic read and write an external asynchronous static RAM of 128K bytes. A client asks for one access through a simple request port that carries the address, a write flag and the write data. The controller then runs the memory's pins through a fixed sequence of states and raises a one-cycle done strobe when the access is finished. For a read, the fetched byte is presented on that same cycle.

Every analog timing minimum of the memory is met by holding each phase for a whole number of clock cycles. The read access, write setup, write pulse, write hold and bus turnaround lengths are parameters, each rounded up from the nanosecond figure for the chosen clock. The defaults suit a 10 ns clock. The memory is enabled through a pair of selects, one active low and one active high, which always switch together. The shared data bus is presented as separate out, out-enable and in signals for the pad ring.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted and after it, until the first request: active-low select high, active-high select low, output enable high, write enable high, bus drive off and done low.
- R2: A read holds the address, both selects active, output enable low and write enable high for exactly RD_CYC cycles. The byte on the data input at the end of that window is registered to the read data output on the same cycle that done pulses.
- R3: A write keeps selects active with write enable high for WR_SETUP_CYC cycles, then holds write enable low for exactly WR_PULSE_CYC cycles, then high again for WR_HOLD_CYC cycles before done pulses.
- R4: The data bus is driven only while write enable is low and during the WR_HOLD_CYC hold cycles that follow, and it carries the write data of the request. It is never driven while the memory is enabled to drive.
- R5: Output enable stays high in every cycle of a write. It is low only during the read access window.
- R6: A write that follows a read waits TURN_CYC extra cycles with both selects inactive before its setup phase. In back-to-back operation this gives at least 1 + TURN_CYC deselected cycles, against 1 in other cases.
- R7: A request made while an access is in progress is ignored. It produces no done pulse and leaves the memory contents unchanged.
- R8: Done is high for exactly one cycle per accepted request. A request presented in that same cycle is accepted at once.
- R9: Write enable is low only while both selects are active, and the two selects are always complementary.
- R10: The memory address stays stable for as long as the selects are active, across the whole 17-bit range including 0x00000 and 0x1FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, sampled when idle |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 17 | Byte address of the request |
| req_wdata_i | input | 8 | Write data of the request |
| rsp_rdata_o | output | 8 | Read data, valid with done |
| rsp_done_o | output | 1 | One-cycle completion strobe |
| mem_addr_o | output | 17 | Memory address pins |
| mem_sel_n_o | output | 1 | Active-low memory select |
| mem_sel_o | output | 1 | Active-high memory select |
| mem_oe_n_o | output | 1 | Active-low output enable |
| mem_we_n_o | output | 1 | Active-low write enable |
| mem_dq_o | output | 8 | Data bus value to drive |
| mem_dq_oe_o | output | 1 | Data bus drive enable |
| mem_dq_i | input | 8 | Data bus value sampled from pad |

## Verification
The assertions assume that reset starts the sequencer in idle and that the request inputs are steady around the clock edge. The bench meets this by changing every request input only on the falling edge. The assertions make no assumption about the data input. The bench models the memory so that it drives the bus only while it is selected and enabled, and it updates that model on the falling edge. The captured read byte is therefore settled well before the sampling edge. Stray requests are issued only in the middle of an access, so the checks see them arrive while the controller is busy.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_TURN,
    ST_WSU,
    ST_WPUL,
    ST_WHLD
  } seq_st_e;
endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W        = 3,
  parameter int RD_CYC       = 6,
  parameter int WR_SETUP_CYC = 1,
  parameter int WR_PULSE_CYC = 5,
  parameter int WR_HOLD_CYC  = 1,
  parameter int TURN_CYC     = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             req_wr_i,
  input  logic             tmr_zero_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output seq_st_e          state_d_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             wdone_o
);
  seq_st_e state_q, state_d;
  logic    last_rd_q;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        tmr_load_o = 1'b1;
        if (!req_wr_i) begin
          state_d   = ST_RD;
          tmr_val_o = CNT_W'(RD_CYC - 1);
        end else if (last_rd_q) begin
          state_d   = ST_TURN;
          tmr_val_o = CNT_W'(TURN_CYC - 1);
        end else begin
          state_d   = ST_WSU;
          tmr_val_o = CNT_W'(WR_SETUP_CYC - 1);
        end
      end
      ST_RD:   if (tmr_zero_i) state_d = ST_IDLE;
      ST_TURN: if (tmr_zero_i) begin
        state_d    = ST_WSU;
        tmr_load_o = 1'b1;
        tmr_val_o  = CNT_W'(WR_SETUP_CYC - 1);
      end
      ST_WSU:  if (tmr_zero_i) begin
        state_d    = ST_WPUL;
        tmr_load_o = 1'b1;
        tmr_val_o  = CNT_W'(WR_PULSE_CYC - 1);
      end
      ST_WPUL: if (tmr_zero_i) begin
        state_d    = ST_WHLD;
        tmr_load_o = 1'b1;
        tmr_val_o  = CNT_W'(WR_HOLD_CYC - 1);
      end
      ST_WHLD: if (tmr_zero_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      last_rd_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_RD)       last_rd_q <= 1'b1;
      else if (state_q == ST_WSU) last_rd_q <= 1'b0;
    end
  end

  assign state_d_o = state_d;
  assign accept_o  = (state_q == ST_IDLE) && req_i;
  assign capture_o = (state_q == ST_RD) && tmr_zero_i;
  assign wdone_o   = (state_q == ST_WHLD) && tmr_zero_i;

  // R7: no request, no departure from idle
  a_r7_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !req_i) |=> (state_q == ST_IDLE));
  // R3: pulse phase only ever ends in hold
  a_r3_pulse_to_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WPUL) |=> (state_q == ST_WPUL || state_q == ST_WHLD));
  // R2: read access returns straight to idle
  a_r2_read_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD) |=> (state_q == ST_RD || state_q == ST_IDLE));
  // R6: turnaround only leads into setup
  a_r6_turn_to_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TURN) |=> (state_q == ST_TURN || state_q == ST_WSU));
endmodule

// File: rtl/sram_ctrl_pins.sv
module sram_ctrl_pins
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  seq_st_e           state_d_i,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic              wdone_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              sel_n_o,
  output logic              sel_o,
  output logic              oe_n_o,
  output logic              we_n_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);
  logic sel_d, drive_d;

  assign sel_d   = (state_d_i == ST_RD)   || (state_d_i == ST_WSU) ||
                   (state_d_i == ST_WPUL) || (state_d_i == ST_WHLD);
  assign drive_d = (state_d_i == ST_WPUL) || (state_d_i == ST_WHLD);

  // every pin comes straight from a flop: no glitches on strobes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      dq_o    <= '0;
      sel_n_o <= 1'b1;
      sel_o   <= 1'b0;
      oe_n_o  <= 1'b1;
      we_n_o  <= 1'b1;
      dq_oe_o <= 1'b0;
      rdata_o <= '0;
      done_o  <= 1'b0;
    end else begin
      if (accept_i) begin
        addr_o <= addr_i;
        dq_o   <= wdata_i;
      end
      sel_n_o <= !sel_d;
      sel_o   <= sel_d;
      oe_n_o  <= (state_d_i != ST_RD);
      we_n_o  <= (state_d_i != ST_WPUL);
      dq_oe_o <= drive_d;
      if (capture_i) rdata_o <= dq_i;
      done_o  <= capture_i | wdone_i;
    end
  end

  a_r5_oe_high_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_o |-> oe_n_o);
  a_r4_no_contention: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (oe_n_o && !sel_n_o));
  a_r4_drive_with_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_n_o) |-> dq_oe_o);
  a_r9_we_needs_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_o |-> (!sel_n_o && sel_o));
  a_r10_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_n_o && $past(!sel_n_o)) |-> $stable(addr_o));
  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int DATA_W       = 8,
  parameter int RD_CYC       = 6,
  parameter int WR_SETUP_CYC = 1,
  parameter int WR_PULSE_CYC = 5,
  parameter int WR_HOLD_CYC  = 1,
  parameter int TURN_CYC     = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req_wr_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_done_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_sel_n_o,
  output logic              mem_sel_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int MAX_A   = (RD_CYC > WR_PULSE_CYC) ? RD_CYC : WR_PULSE_CYC;
  localparam int MAX_B   = (WR_SETUP_CYC > WR_HOLD_CYC) ? WR_SETUP_CYC : WR_HOLD_CYC;
  localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_CYC = (MAX_C > TURN_CYC) ? MAX_C : TURN_CYC;
  localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  logic             tmr_load, tmr_zero, accept, capture, wdone;
  logic [CNT_W-1:0] tmr_val;
  seq_st_e          state_d;

  sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  sram_ctrl_seq #(
    .CNT_W        (CNT_W),
    .RD_CYC       (RD_CYC),
    .WR_SETUP_CYC (WR_SETUP_CYC),
    .WR_PULSE_CYC (WR_PULSE_CYC),
    .WR_HOLD_CYC  (WR_HOLD_CYC),
    .TURN_CYC     (TURN_CYC)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .req_wr_i   (req_wr_i),
    .tmr_zero_i (tmr_zero),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .state_d_o  (state_d),
    .accept_o   (accept),
    .capture_o  (capture),
    .wdone_o    (wdone)
  );

  sram_ctrl_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_d_i (state_d),
    .accept_i  (accept),
    .capture_i (capture),
    .wdone_i   (wdone),
    .addr_i    (req_addr_i),
    .wdata_i   (req_wdata_i),
    .dq_i      (mem_dq_i),
    .addr_o    (mem_addr_o),
    .sel_n_o   (mem_sel_n_o),
    .sel_o     (mem_sel_o),
    .oe_n_o    (mem_oe_n_o),
    .we_n_o    (mem_we_n_o),
    .dq_o      (mem_dq_o),
    .dq_oe_o   (mem_dq_oe_o),
    .rdata_o   (rsp_rdata_o),
    .done_o    (rsp_done_o)
  );
endmodule

// File: tb/sram_ctrl_test.sv
module sram_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int RD_CYC = 6, WR_SETUP_CYC = 1, WR_PULSE_CYC = 5;
  localparam int WR_HOLD_CYC = 1, TURN_CYC = 1;

  typedef struct packed {logic wr; logic [16:0] addr; logic [7:0] data;} exp_t;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, req_wr = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  rdata, mem_dq_o, mem_dq_i;
  logic        done, sel_n, sel, oe_n, we_n, dq_oe;
  logic [16:0] mem_addr;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  exp_t exp_q[$];
  logic [7:0] model_mem [int];
  logic [7:0] ref_mem [int];

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_wr_i(req_wr),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_rdata_o(rdata), .rsp_done_o(done),
    .mem_addr_o(mem_addr), .mem_sel_n_o(sel_n), .mem_sel_o(sel),
    .mem_oe_n_o(oe_n), .mem_we_n_o(we_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe_o(dq_oe), .mem_dq_i(mem_dq_i)
  );

  function automatic logic [7:0] init_val(logic [16:0] a);
    return a[7:0] ^ {a[16:15], a[13:8]} ^ 8'h5A;
  endfunction

  function automatic logic [7:0] ref_rd(logic [16:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : init_val(a);
  endfunction

  function automatic logic [7:0] model_rd(logic [16:0] a);
    return model_mem.exists(int'(a)) ? model_mem[int'(a)] : init_val(a);
  endfunction

  task automatic check(input bit ok, input string req_tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req_tag, act, expv, $time);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  // memory model, scoreboard monitor and pin timing checks
  int  oe_run = 0, we_run = 0, hold_run = 0, su_run = 0, desel_run = 0;
  bit  prev_done = 0, last_was_rd = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      oe_run = 0; we_run = 0; hold_run = 0; su_run = 0; desel_run = 0;
      prev_done = 0; last_was_rd = 0;
      mem_dq_i = 8'hzz;
    end else begin
      if (sel_n != !sel) check(0, "R9 select pair", sel_n, !sel);
      if (!sel_n && sel && !we_n && dq_oe) model_mem[int'(mem_addr)] = mem_dq_o;
      if (dq_oe && !sel_n && !oe_n && we_n) check(0, "R4 contention", 1, 0);
      mem_dq_i = (!sel_n && sel && !oe_n && we_n) ? model_rd(mem_addr) : 8'hzz;

      if (!oe_n) oe_run++;
      else if (oe_run != 0) begin check(oe_run == RD_CYC, "R2 access cycles", oe_run, RD_CYC); oe_run = 0; end
      if (!we_n) we_run++;
      else if (we_run != 0) begin check(we_run == WR_PULSE_CYC, "R3 pulse cycles", we_run, WR_PULSE_CYC); we_run = 0; end
      if (dq_oe && we_n) hold_run++;
      else if (hold_run != 0) begin check(hold_run == WR_HOLD_CYC, "R4 hold cycles", hold_run, WR_HOLD_CYC); hold_run = 0; end
      if (!sel_n && we_n && oe_n && !dq_oe) su_run++;
      else if (su_run != 0) begin
        check(su_run == WR_SETUP_CYC, "R3 setup cycles", su_run, WR_SETUP_CYC);
        check(!we_n, "R5 setup ends in pulse", oe_n, 1);
        su_run = 0;
      end
      if (dq_oe) check(oe_n == 1'b1, "R5 oe during write", oe_n, 1);

      if (sel_n) desel_run++;
      else if (desel_run != 0) begin
        int need;
        need = (last_was_rd && oe_n) ? 1 + TURN_CYC : 1;
        check(desel_run >= need, "R6 deselected gap", desel_run, need);
        last_was_rd = !oe_n;
        desel_run = 0;
      end

      if (done) begin
        if (prev_done) check(0, "R8 done width", 1, 0);
        if (exp_q.size() == 0) check(0, "R7 unexpected done", 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          if (e.wr) check(model_rd(e.addr) == e.data, "R3 stored byte", model_rd(e.addr), e.data);
          else      check(rdata == e.data, "R2 read data", rdata, e.data);
        end
      end
      prev_done = done;
    end
  end

  // issue one request at the current falling edge, return at the edge done is seen
  task automatic do_op(input bit wr, input logic [16:0] a, input logic [7:0] d, input bit stray);
    exp_t e;
    e.wr = wr; e.addr = a;
    if (wr) begin ref_mem[int'(a)] = d; e.data = d; end
    else e.data = ref_rd(a);
    exp_q.push_back(e);
    req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 1'b0;
    if (stray) begin  // R7: busy-time request must be dropped
      @(negedge clk);
      req = 1'b1; req_wr = 1'b1; req_addr = a ^ 17'h00155; req_wdata = ~d;
      @(negedge clk);
      req = 1'b0;
    end
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check(sel_n == 1'b1, "R1 sel_n", sel_n, 1);
    check(sel == 1'b0, "R1 sel", sel, 0);
    check(oe_n == 1'b1, "R1 oe_n", oe_n, 1);
    check(we_n == 1'b1, "R1 we_n", we_n, 1);
    check(dq_oe == 1'b0, "R1 dq_oe", dq_oe, 0);
    check(done == 1'b0, "R1 done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(sel_n && !done && we_n && oe_n, "R1 idle after reset", sel_n, 1);

    // R10: range ends, R2/R3 basic, back-to-back (R8) and write after write (R6)
    do_op(1, 17'h00000, 8'hA5, 0);
    do_op(0, 17'h00000, 8'h00, 0);
    do_op(1, 17'h1FFFF, 8'hFF, 0);
    do_op(1, 17'h1FFFE, 8'h00, 0);
    do_op(0, 17'h1FFFF, 8'h00, 0);
    do_op(0, 17'h1FFFE, 8'h00, 0);
    do_op(0, 17'h12345, 8'h00, 0);
    // R6: read then write back to back
    do_op(1, 17'h00100, 8'h3C, 0);
    // R7: stray request during a write and during a read
    do_op(1, 17'h00200, 8'h96, 1);
    do_op(0, 17'h00200 ^ 17'h00155, 8'h00, 0);
    do_op(0, 17'h00100, 8'h00, 1);
    do_op(0, 17'h00100 ^ 17'h00155, 8'h00, 0);
    do_op(0, 17'h00200, 8'h00, 0);
    // gaps between requests
    for (int i = 0; i < 8; i++) begin
      repeat (i % 3) @(negedge clk);
      do_op(i[0], 17'(17'h0A000 + i * 17'h00111), 8'(i * 37 + 5), 0);
      do_op(0, 17'(17'h0A000 + i * 17'h00111), 8'h00, 0);
    end
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R8 all requests done", exp_q.size(), 0);
    finished = 1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R8 watchdog: actual hang expected completion");
      summary();
    end
  end
endmodule